// File: doc/BRIEF.md
# Tiled-Region Fence Register Sequencer

This block turns a descriptor of a tiled memory region into a fence register value and writes that value into a register file through a 32-bit write port. The descriptor gives the region base address, its size in bytes, the row stride, a tiled flag and a Y-tiling flag. In the wide format the fence value is 64 bits and goes out as two 32-bit writes. The block orders those writes so that a fence with its valid bit set never sits next to a stale other half. A mode input selects a legacy format that fits into one 32-bit word and takes a single write.

Each write step is confirmed before the next one starts. The block issues a read on the same port and waits for the register file to return its response strobe. The block accepts a descriptor on a one-cycle start strobe. It either runs the write sequence and pulses `done_o`, or rejects a stride it cannot encode by pulsing `err_o` without touching the register file.

States:
- `ST_IDLE`: waits for start.
- `ST_CLR_LO`: writes zero to the low word.
- `ST_RB1_REQ`: issues the first read.
- `ST_RB1_WAIT`: waits for the first response.
- `ST_WR_HI`: writes the high word.
- `ST_WR_LO`: writes the low word.
- `ST_RB2_REQ`: issues the final read.
- `ST_RB2_WAIT`: waits for the final response.
- `ST_FIN`: pulses done.

Transitions:
- Wide mode: IDLE→CLR_LO→RB1_REQ→RB1_WAIT.
- RB1_WAIT moves to WR_HI when the response arrives.
- From WR_HI: WR_HI→WR_LO→RB2_REQ→RB2_WAIT.
- RB2_WAIT moves to FIN when the response arrives.
- FIN→IDLE.
- Legacy mode goes from IDLE straight to WR_LO.
- A rejected descriptor leaves the block in IDLE.

Top module: `fence_writer`

## Requirements
- R1: With `tiled_i` low, every word written is zero in both formats. The write sequence of the selected format still runs.
- R2: Wide format high word is base + size − 4096. Its low word is composed as follows:
  - bits [31:12] hold base[31:12];
  - bit 1 is the Y flag;
  - bit 0 is the valid bit, set whenever tiled.
- R3: The wide pitch field is stride/128 − 1. It is PITCH_W (10) bits wide and sits at bit PITCH_SHIFT (2). The stride must be a multiple of 128.
- R4: A wide update writes in this order:
  1. the low word (address select 0) with zero;
  2. a read;
  3. the high word (select 1);
  4. the low word;
  5. a read.
- R5: No write is issued while a read response is pending. The high-word write comes in the cycle after the first read response.
- R6: The legacy format writes one word, to the low word, followed by one read. Its fields are:
  - base[31:20] in bits [31:20];
  - log2(size) − 20 in bits [11:8];
  - the pitch code in bits [6:4];
  - the Y flag in bit 1;
  - the valid bit in bit 0;
  - all other bits zero.
- R7: The legacy pitch code is log2(stride/unit). The unit is 128 bytes when both the Y flag and `y128_ok_i` are set, and 512 bytes otherwise. The stride must be an exact power-of-two multiple of the unit.
- R8: A tiled descriptor that breaks R3 (wide) or R7 (legacy) makes `err_o` pulse in the cycle after start. No read or write follows, and `done_o` stays low.
- R9: `done_o` is high for exactly one cycle, the cycle after the final read response.
- R10: A start strobe while a sequence is running is ignored. The running update completes with its original values and only one done pulse.
- R11: After reset, no write or read is issued and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle request to program a fence |
| legacy_i | input | 1 | 1 selects the single-word legacy format |
| tiled_i | input | 1 | Region is tiled (0 clears the fence) |
| ytile_i | input | 1 | Y tiling (0 = X tiling) |
| y128_ok_i | input | 1 | Legacy: 128-byte Y pitch unit available |
| base_i | input | 32 | Region base address (4 KiB aligned) |
| span_i | input | 32 | Region size in bytes |
| stride_i | input | STRIDE_W | Row stride in bytes |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read-back request |
| reg_hi_sel_o | output | 1 | Word select: 1 high word, 0 low word |
| reg_wdata_o | output | 32 | Write data |
| reg_rvalid_i | input | 1 | Read response strobe from register file |
| done_o | output | 1 | Update complete pulse |
| err_o | output | 1 | Descriptor rejected pulse |

## Verification
The hardest condition to reach from the ports is a second start arriving mid-sequence while a read response is still outstanding. The bench's register model returns responses after a programmable latency. A scenario raises start again, with a different base address, two cycles into a wide update. It then checks that the write log holds only the first descriptor's words and that exactly one done pulse occurred. The same model counts any write issued while a read is pending. It also timestamps the last response so that the done gap can be measured.

// File: rtl/fence_pkg.sv
package fence_pkg;

    localparam logic [31:0] PAGE_BYTES = 32'd4096;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_LO,
        ST_RB1_REQ,
        ST_RB1_WAIT,
        ST_WR_HI,
        ST_WR_LO,
        ST_RB2_REQ,
        ST_RB2_WAIT,
        ST_FIN
    } fseq_state_e;

    function automatic logic is_pow2(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction

    function automatic logic [4:0] msb_idx(input logic [31:0] v);
        logic [4:0] r;
        r = 5'd0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/fence_encode.sv
module fence_encode
    import fence_pkg::*;
#(
    parameter int STRIDE_W    = 16,
    parameter int PITCH_W     = 10,
    parameter int PITCH_SHIFT = 2
) (
    input  logic [31:0]         base,
    input  logic [31:0]         span,
    input  logic [STRIDE_W-1:0] stride,
    input  logic                tiled,
    input  logic                ytile,
    input  logic                legacy,
    input  logic                y128_ok,
    output logic [31:0]         word_hi,
    output logic [31:0]         word_lo,
    output logic                bad
);
    localparam int SW32 = 32;

    logic [31:0] stride32;
    logic [31:0] pitch_w;
    logic        unit128;
    logic [31:0] quot;
    logic        low_ok;
    logic [4:0]  pcode;
    logic [4:0]  scode;

    always_comb begin
        stride32 = SW32'(stride);
        pitch_w  = ((stride32 >> 7) - 32'd1) & ((32'd1 << PITCH_W) - 32'd1);
        unit128  = ytile && y128_ok;
        quot     = unit128 ? (stride32 >> 7) : (stride32 >> 9);
        low_ok   = unit128 ? (stride32[6:0] == 7'd0) : (stride32[8:0] == 9'd0);
        pcode    = msb_idx(quot);
        scode    = msb_idx(span) - 5'd20;

        word_hi = 32'd0;
        word_lo = 32'd0;
        bad     = 1'b0;
        if (tiled) begin
            if (legacy) begin
                bad     = !low_ok || !is_pow2(quot);
                word_lo = {base[31:20], 8'd0, scode[3:0], 1'b0, pcode[2:0], 2'b00, ytile, 1'b1};
            end else begin
                bad     = (stride32[6:0] != 7'd0) || (stride32 == 32'd0);
                word_hi = base + span - PAGE_BYTES;
                word_lo = {base[31:12], 12'd0} | (pitch_w << PITCH_SHIFT)
                          | {30'd0, ytile, 1'b1};
            end
        end
    end
endmodule

// File: rtl/fence_seq.sv
module fence_seq
    import fence_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        legacy,
    input  logic        bad,
    input  logic [31:0] hi_in,
    input  logic [31:0] lo_in,
    input  logic        rvalid,
    output logic        we,
    output logic        re,
    output logic        sel_hi,
    output logic [31:0] wdata,
    output logic        done,
    output logic        err
);
    fseq_state_e state, nxt;
    logic [31:0] hi_q, lo_q;
    logic        err_q;
    logic        accept;

    assign accept = (state == ST_IDLE) && start && !bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hi_q  <= '0;
            lo_q  <= '0;
            err_q <= 1'b0;
        end else begin
            state <= nxt;
            err_q <= (state == ST_IDLE) && start && bad;
            if (accept) begin
                hi_q <= hi_in;
                lo_q <= lo_in;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (accept) nxt = legacy ? ST_WR_LO : ST_CLR_LO;
            ST_CLR_LO:   nxt = ST_RB1_REQ;
            ST_RB1_REQ:  nxt = ST_RB1_WAIT;
            ST_RB1_WAIT: if (rvalid) nxt = ST_WR_HI;
            ST_WR_HI:    nxt = ST_WR_LO;
            ST_WR_LO:    nxt = ST_RB2_REQ;
            ST_RB2_REQ:  nxt = ST_RB2_WAIT;
            ST_RB2_WAIT: if (rvalid) nxt = ST_FIN;
            ST_FIN:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        we     = 1'b0;
        re     = 1'b0;
        sel_hi = 1'b0;
        wdata  = 32'd0;
        done   = 1'b0;
        err    = err_q;
        unique case (state)
            ST_CLR_LO:  we = 1'b1;
            ST_WR_HI:   begin we = 1'b1; sel_hi = 1'b1; wdata = hi_q; end
            ST_WR_LO:   begin we = 1'b1; wdata = lo_q; end
            ST_RB1_REQ, ST_RB2_REQ: re = 1'b1;
            ST_FIN:     done = 1'b1;
            default:    ;
        endcase
    end

    // R9: done only in the cycle after a read response
    p_done_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rvalid));
    // R5: high word written only right after the first response
    p_hi_after_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_hi) |-> $past(rvalid));
    // R8: a rejection answers a start and writes nothing
    p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!we && !re && $past(start)));
    // R10: start while busy leaves captured words untouched
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> ($stable(hi_q) && $stable(lo_q)));
    // R4: in wide mode a non-zero low word directly follows the high word
    p_valid_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel_hi && wdata != 32'd0 && !$past(state == ST_IDLE)) |-> $past(we && sel_hi));
endmodule

// File: rtl/fence_writer.sv
module fence_writer #(
    parameter int STRIDE_W    = 16,
    parameter int PITCH_W     = 10,
    parameter int PITCH_SHIFT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                legacy_i,
    input  logic                tiled_i,
    input  logic                ytile_i,
    input  logic                y128_ok_i,
    input  logic [31:0]         base_i,
    input  logic [31:0]         span_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic                reg_we_o,
    output logic                reg_re_o,
    output logic                reg_hi_sel_o,
    output logic [31:0]         reg_wdata_o,
    input  logic                reg_rvalid_i,
    output logic                done_o,
    output logic                err_o
);
    logic [31:0] enc_hi, enc_lo;
    logic        enc_bad;

    fence_encode #(
        .STRIDE_W(STRIDE_W), .PITCH_W(PITCH_W), .PITCH_SHIFT(PITCH_SHIFT)
    ) u_enc (
        .base(base_i), .span(span_i), .stride(stride_i), .tiled(tiled_i),
        .ytile(ytile_i), .legacy(legacy_i), .y128_ok(y128_ok_i),
        .word_hi(enc_hi), .word_lo(enc_lo), .bad(enc_bad)
    );

    fence_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_i), .legacy(legacy_i),
        .bad(enc_bad), .hi_in(enc_hi), .lo_in(enc_lo), .rvalid(reg_rvalid_i),
        .we(reg_we_o), .re(reg_re_o), .sel_hi(reg_hi_sel_o), .wdata(reg_wdata_o),
        .done(done_o), .err(err_o)
    );
endmodule

// File: tb/tb_fence_writer.sv
`timescale 1ns/1ps
module tb_fence_writer;
    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic start = 0, legacy = 0, tiled = 0, ytile = 0, y128 = 0;
    logic [31:0] base = 0, span = 0;
    logic [15:0] stride = 0;
    logic we, re, hsel, rvalid, done, err;
    logic [31:0] wdata;

    fence_writer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .legacy_i(legacy),
        .tiled_i(tiled), .ytile_i(ytile), .y128_ok_i(y128), .base_i(base),
        .span_i(span), .stride_i(stride), .reg_we_o(we), .reg_re_o(re),
        .reg_hi_sel_o(hsel), .reg_wdata_o(wdata), .reg_rvalid_i(rvalid),
        .done_o(done), .err_o(err)
    );

    int checks = 0, errors = 0;
    logic clr = 0;
    int lat = 1, cnt = 0, nlog = 0, nreads = 0, ndone = 0, viol = 0, cyc = 0, rv_cyc = 0;
    logic        log_sel [8];
    logic [31:0] log_dat [8];
    assign rvalid = (cnt == 1);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rvalid) rv_cyc <= cyc;
        if (clr) begin
            nlog <= 0; nreads <= 0; ndone <= 0; viol <= 0; cnt <= 0;
        end else begin
            if (we) begin
                if (nlog < 8) begin log_sel[nlog] <= hsel; log_dat[nlog] <= wdata; end
                nlog <= nlog + 1;
                if (cnt != 0) viol <= viol + 1;
            end
            if (re) begin cnt <= lat; nreads <= nreads + 1; end
            else if (cnt != 0) cnt <= cnt - 1;
            if (done) ndone <= ndone + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_hi(input logic [31:0] b, input logic [31:0] s);
        return b + s - 32'h1000;
    endfunction
    function automatic logic [31:0] exp_lo(input logic [31:0] b, input int st, input logic y);
        return (b & 32'hFFFF_F000) | (32'(st / 128 - 1) << 2) | (y ? 32'h2 : 32'h0) | 32'h1;
    endfunction
    function automatic int lg2(input longint v);
        int n = 0;
        while (v > 1) begin v = v / 2; n++; end
        return n;
    endfunction
    function automatic logic [31:0] exp_leg(input logic [31:0] b, input longint s,
                                            input int st, input logic y, input logic u128);
        int unit = (y && u128) ? 128 : 512;
        return (b & 32'hFFF0_0000) | (32'(lg2(s) - 20) << 8) | (32'(lg2(st / unit)) << 4)
               | (y ? 32'h2 : 32'h0) | 32'h1;
    endfunction

    int saw_done_k, saw_err_k, gap;
    task automatic run(input logic lg, input logic t, input logic y, input logic u,
                       input logic [31:0] b, input logic [31:0] s, input int st,
                       input int l, input logic poke);
        @(negedge clk);
        clr = 1; lat = l;
        @(negedge clk);
        clr = 0;
        legacy = lg; tiled = t; ytile = y; y128 = u; base = b; span = s; stride = 16'(st);
        start = 1;
        @(negedge clk);
        start = 0;
        saw_done_k = -1; saw_err_k = -1; gap = -1;
        for (int k = 0; k < 60; k++) begin
            if (done && saw_done_k < 0) begin saw_done_k = k; gap = cyc - rv_cyc; end
            if (err && saw_err_k < 0) saw_err_k = k;
            if (poke && k == 2) begin start = 1; base = 32'h0ABC_D000; end
            if (poke && k == 3) start = 0;
            @(negedge clk);
        end
    endtask

    task automatic check_wide(input string tag, input logic [31:0] b, input logic [31:0] s,
                              input logic [31:0] h, input logic [31:0] lo);
        chk({tag, " R4 write count"}, nlog, 3);
        chk({tag, " R4 first clears low"}, {log_sel[0], log_dat[0]}, {1'b0, 32'd0});
        chk({tag, " R2 high word"}, {log_sel[1], log_dat[1]}, {1'b1, h});
        chk({tag, " R3 low word last"}, {log_sel[2], log_dat[2]}, {1'b0, lo});
        chk({tag, " R4 reads"}, nreads, 2);
        chk({tag, " R5 no write during read"}, viol, 0);
        chk({tag, " R9 one done"}, ndone, 1);
        chk({tag, " R9 done gap"}, gap, 1);
    endtask

    task automatic t_reset;
        chk("R11 we", we, 0); chk("R11 re", re, 0);
        chk("R11 done", done, 0); chk("R11 err", err, 0);
    endtask

    task automatic t_wide_x;
        run(0, 1, 0, 0, 32'h0010_0000, 32'h0004_0000, 512, 1, 0);
        check_wide("wideX", 0, 0, 32'h0013_F000, 32'h0010_000D);
    endtask

    task automatic t_wide_y;
        run(0, 1, 1, 0, 32'h0234_5000, 32'h0001_0000, 2048, 3, 0);
        check_wide("wideY", 0, 0, exp_hi(32'h0234_5000, 32'h0001_0000),
                   exp_lo(32'h0234_5000, 2048, 1));
    endtask

    task automatic t_wide_untiled;
        run(0, 0, 1, 0, 32'h0234_5000, 32'h0001_0000, 2048, 2, 0);
        check_wide("R1 wide", 0, 0, 32'd0, 32'd0);
    endtask

    task automatic t_leg(input logic y, input logic u, input logic [31:0] b,
                         input logic [31:0] s, input int st, input string tag);
        run(1, 1, y, u, b, s, st, 2, 0);
        chk({tag, " R6 one write"}, nlog, 1);
        chk({tag, " R6/R7 word"}, {log_sel[0], log_dat[0]}, {1'b0, exp_leg(b, s, st, y, u)});
        chk({tag, " R6 one read"}, nreads, 1);
        chk({tag, " R9 done gap"}, gap, 1);
    endtask

    task automatic t_leg_untiled;
        run(1, 0, 1, 1, 32'h0340_0000, 32'h0020_0000, 1024, 1, 0);
        chk("R1 legacy write count", nlog, 1);
        chk("R1 legacy zero", log_dat[0], 0);
    endtask

    task automatic t_bad(input logic lg, input logic y, input logic u, input int st,
                         input string tag);
        run(lg, 1, y, u, 32'h0100_0000, 32'h0010_0000, st, 1, 0);
        chk({tag, " R8 err next cycle"}, saw_err_k, 0);
        chk({tag, " R8 no writes"}, nlog, 0);
        chk({tag, " R8 no reads"}, nreads, 0);
        chk({tag, " R8 no done"}, ndone, 0);
    endtask

    task automatic t_busy;
        run(0, 1, 0, 0, 32'h0010_0000, 32'h0004_0000, 512, 4, 1);
        check_wide("R10 busy", 0, 0, 32'h0013_F000, 32'h0010_000D);
        chk("R10 no err", saw_err_k, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_wide_x();
        t_wide_y();
        t_wide_untiled();
        t_leg(1, 1, 32'h0340_0000, 32'h0020_0000, 1024, "legY128");
        t_leg(0, 1, 32'h0120_0000, 32'h0010_0000, 2048, "legX");
        t_leg(1, 0, 32'h0560_0000, 32'h0040_0000, 2048, "R7 legY512");
        t_leg_untiled();
        t_bad(0, 0, 0, 200, "wide misaligned");
        t_bad(1, 1, 1, 384, "legacy nonpow2");
        t_bad(1, 0, 1, 256, "R7 legacy 512 unit");
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule